// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the controller-side command bus of a DDR SDRAM module. On each rising clock edge it registers chip select, the three command strobes (row, column and write enable, all active low), the bank address, the address bus and clock enable. It turns the registered pins into one decoded command and keeps a map of which of the four banks hold an open row. It also holds the contents of the base and extended mode registers, and it classifies the power state of the device.

A testbench or a larger checker uses it as a protocol monitor. Two one-cycle flags report misuse. One flags a command that does not fit the bank map. The other flags clock enable falling while a read or write access is still running. All state changes take effect on the clock edge after the one that captured the command. The decoded command is visible right after the capture edge.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Pins are captured on the rising edge. After that edge `cmdOut` shows the decoded command, coded as 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 SELF REFRESH, 7 LOAD MODE REGISTER, 8 BURST TERMINATE. With chip select low, the strobes {RAS#,CAS#,WE#} decode as 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 refresh, 000 LOAD MODE, 110 BURST TERMINATE.
- R2: A command captured with chip select high decodes as NOP and changes no state.
- R3: ACTIVE sets bit `ba` of `bankOpen` on the edge after capture.
- R4: ACTIVE to an open bank, or READ/WRITE to a closed bank, pulses `bankErr` high for exactly one cycle and leaves `bankOpen` unchanged.
- R5: For PRECHARGE, address bit 10 low clears only bank `ba`, and address bit 10 high clears all banks.
- R6: READ/WRITE with address bit 10 high closes its bank BURST_CYC+1 edges after the capture edge (5 with the default of 4). With bit 10 low the bank stays open.
- R7: LOAD MODE with `ba`=0 loads `addr` into `modeBase`, and with `ba`=1 loads it into `modeExt`. With `ba`=2 or 3 neither register changes.
- R8: `powerState` is coded as 0 active, 1 precharge power-down, 2 active power-down, 3 self refresh. CKE captured low while active enters 1 if all banks are closed, or 2 if any bank is open.
- R9: A refresh code captured with CKE low and all banks closed decodes as SELF REFRESH and enters state 3. With a bank open, the same capture enters state 2.
- R10: In any power-down or self-refresh state, and on the capture that enters one, commands decode as NOP and change no bank or mode state.
- R11: The first capture of CKE high in a low-power state returns `powerState` to 0 on the next edge. The command captured with it is ignored.
- R12: CKE captured low on any of the BURST_CYC captures following a READ/WRITE pulses `ckeErr` for one cycle. The block then enters state 2 and drops any pending auto-precharge. CKE captured low on a later capture raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus / mode op-code |
| cmdOut | output | 4 | Decoded command of the last capture |
| powerState | output | 2 | Power state classification |
| bankOpen | output | 2**BA_W | One bit per bank, set while a row is open |
| bankErr | output | 1 | One-cycle pulse on a bank-state misuse |
| ckeErr | output | 1 | One-cycle pulse on CKE falling during an access |
| modeBase | output | ADDR_W | Base mode register contents |
| modeExt | output | ADDR_W | Extended mode register contents |

## Verification
The assertions assume that reset is held long enough for the captured clock enable to read high. They also assume that no new READ/WRITE or ACTIVE is aimed at a bank whose auto-precharge closes on the same edge. The stimulus returns to a known bank map between steps and gives every access time to finish before it targets that bank again. A full sweep of the chip-select and strobe codes over all four banks, with CKE high, checks the decode. Directed sequences then cover both power-down flavours, self refresh, exit, and the edges of the burst window.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_READ  = 4'd2,
    CMD_WRITE = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_REF   = 4'd5,
    CMD_SREF  = 4'd6,
    CMD_LMR   = 4'd7,
    CMD_BST   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_PRE_PD = 2'd1,
    PS_ACT_PD = 2'd2,
    PS_SREF   = 2'd3
  } pwr_e;

  typedef struct packed {
    logic actEn;
    logic preOne;
    logic preAll;
    logic apClose;
    logic loadBase;
    logic loadExt;
  } strobe_t;
endpackage

// File: rtl/ddr_trk_dp.sv
module ddr_trk_dp
  import ddr_trk_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  localparam int NUM_BANKS = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  input  strobe_t              strb,
  input  logic [BA_W-1:0]      apBank,
  output logic [BA_W-1:0]      baQ,
  output logic                 a10Q,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [ADDR_W-1:0]    modeBase,
  output logic [ADDR_W-1:0]    modeExt
);
  logic [ADDR_W-1:0]    addrQ;
  logic [NUM_BANKS-1:0] bankNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baQ   <= '0;
      addrQ <= '0;
    end else begin
      baQ   <= ba;
      addrQ <= addr;
    end
  end

  assign a10Q = addrQ[AP_BIT];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic selHit;
    logic apHit;
    assign selHit = (baQ == BA_W'(i));
    assign apHit  = (apBank == BA_W'(i));
    assign bankNext[i] =
      (strb.preAll || (strb.preOne && selHit) || (strb.apClose && apHit)) ? 1'b0 :
      (strb.actEn && selHit) ? 1'b1 : bankOpen[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankOpen <= '0;
      modeBase <= '0;
      modeExt  <= '0;
    end else begin
      bankOpen <= bankNext;
      if (strb.loadBase) modeBase <= addrQ;
      if (strb.loadExt)  modeExt  <= addrQ;
    end
  end

  // R7: the two mode registers are never written in the same cycle
  a_r7_single_load: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadBase && strb.loadExt));

  // R7: the mode registers change only on a load strobe
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadBase) && !$past(strb.loadExt) |-> $stable(modeBase) && $stable(modeExt));
endmodule

// File: rtl/ddr_trk_ctrl.sv
module ddr_trk_ctrl
  import ddr_trk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int BURST_CYC = 4,
  localparam int NUM_BANKS = 1 << BA_W,
  localparam int BL_W      = $clog2(BURST_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [BA_W-1:0]      baQ,
  input  logic                 a10Q,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              strb,
  output logic [BA_W-1:0]      apBank,
  output cmd_e                 cmdOut,
  output pwr_e                 powerState,
  output logic                 bankErr,
  output logic                 ckeErr
);
  logic csQ, rasQ, casQ, weQ, ckeQ;
  cmd_e rawCmd;
  pwr_e pwrNext;
  logic [BL_W-1:0] burstLeft;
  logic apPend;
  logic anyOpen, bankHit, isAccess, accessOk, burstBusy, ckeDrop, lastBeat;
  logic cmdLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ  <= 1'b1;
      rasQ <= 1'b1;
      casQ <= 1'b1;
      weQ  <= 1'b1;
      ckeQ <= 1'b1;
    end else begin
      csQ  <= csN;
      rasQ <= rasN;
      casQ <= casN;
      weQ  <= weN;
      ckeQ <= cke;
    end
  end

  always_comb begin
    if (csQ) rawCmd = CMD_NOP;
    else begin
      unique case ({rasQ, casQ, weQ})
        3'b111:  rawCmd = CMD_NOP;
        3'b011:  rawCmd = CMD_ACT;
        3'b101:  rawCmd = CMD_READ;
        3'b100:  rawCmd = CMD_WRITE;
        3'b010:  rawCmd = CMD_PRE;
        3'b001:  rawCmd = CMD_REF;
        3'b000:  rawCmd = CMD_LMR;
        default: rawCmd = CMD_BST;
      endcase
    end
  end

  assign anyOpen = |bankOpen;
  assign cmdLive = (powerState == PS_ACTIVE) && ckeQ;

  always_comb begin
    if (powerState != PS_ACTIVE)  cmdOut = CMD_NOP;
    else if (!ckeQ)               cmdOut = (rawCmd == CMD_REF && !anyOpen) ? CMD_SREF : CMD_NOP;
    else                          cmdOut = rawCmd;
  end

  assign bankHit   = bankOpen[baQ];
  assign isAccess  = (cmdOut == CMD_READ) || (cmdOut == CMD_WRITE);
  assign accessOk  = isAccess && bankHit;
  assign burstBusy = (burstLeft != '0);
  assign ckeDrop   = (powerState == PS_ACTIVE) && !ckeQ && burstBusy;
  assign lastBeat  = (burstLeft == BL_W'(1));

  always_comb begin
    strb          = '0;
    strb.actEn    = (cmdOut == CMD_ACT) && !bankHit;
    strb.preOne   = (cmdOut == CMD_PRE) && !a10Q;
    strb.preAll   = (cmdOut == CMD_PRE) && a10Q;
    strb.loadBase = (cmdOut == CMD_LMR) && (baQ == BA_W'(0));
    strb.loadExt  = (cmdOut == CMD_LMR) && (baQ == BA_W'(1));
    strb.apClose  = apPend && cmdLive && (lastBeat || accessOk || cmdOut == CMD_BST);
  end

  always_comb begin
    pwrNext = powerState;
    unique case (powerState)
      PS_ACTIVE: if (!ckeQ) pwrNext = (cmdOut == CMD_SREF) ? PS_SREF :
                                      (anyOpen ? PS_ACT_PD : PS_PRE_PD);
      default:   if (ckeQ) pwrNext = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerState <= PS_ACTIVE;
      burstLeft  <= '0;
      apPend     <= 1'b0;
      apBank     <= '0;
      bankErr    <= 1'b0;
      ckeErr     <= 1'b0;
    end else begin
      powerState <= pwrNext;
      bankErr    <= ((cmdOut == CMD_ACT) && bankHit) || (isAccess && !bankHit);
      ckeErr     <= ckeDrop;
      if (ckeDrop) begin
        burstLeft <= '0;
        apPend    <= 1'b0;
      end else if (accessOk) begin
        burstLeft <= BL_W'(BURST_CYC);
        apPend    <= a10Q;
        apBank    <= baQ;
      end else if (cmdOut == CMD_BST) begin
        burstLeft <= '0;
        apPend    <= 1'b0;
      end else if (burstBusy) begin
        burstLeft <= burstLeft - BL_W'(1);
        if (lastBeat) apPend <= 1'b0;
      end
    end
  end

  // R6: the burst counter never exceeds its load value
  always_comb a_r6_burst_range: assert (burstLeft <= BL_W'(BURST_CYC));

  // R8: precharge power-down holds only with every bank closed
  a_r8_pre_pd_idle: assert property (@(posedge clk) disable iff (!rstN)
    powerState == PS_PRE_PD |-> bankOpen == '0);

  // R8: active power-down holds only with a row open
  a_r8_act_pd_open: assert property (@(posedge clk) disable iff (!rstN)
    powerState == PS_ACT_PD |-> bankOpen != '0);

  // R9: self refresh holds only with every bank closed
  a_r9_sref_idle: assert property (@(posedge clk) disable iff (!rstN)
    powerState == PS_SREF |-> bankOpen == '0);

  // R10: bank map frozen while staying in a low-power state
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    powerState != PS_ACTIVE && $past(powerState) != PS_ACTIVE |-> $stable(bankOpen));

  // R11: a captured CKE high in a low-power state returns to active
  a_r11_exit: assert property (@(posedge clk) disable iff (!rstN)
    $past(powerState) != PS_ACTIVE && $past(ckeQ) |-> powerState == PS_ACTIVE);

  // R12: a burst-time CKE drop lands in active power-down
  a_r12_err_state: assert property (@(posedge clk) disable iff (!rstN)
    ckeErr |-> powerState == PS_ACT_PD);
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int BURST_CYC = 4,
  localparam int NUM_BANKS = 1 << BA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 cke,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [3:0]           cmdOut,
  output logic [1:0]           powerState,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 bankErr,
  output logic                 ckeErr,
  output logic [ADDR_W-1:0]    modeBase,
  output logic [ADDR_W-1:0]    modeExt
);
  strobe_t         strb;
  logic [BA_W-1:0] apBank;
  logic [BA_W-1:0] baQ;
  logic            a10Q;
  cmd_e            cmdDec;
  pwr_e            pwrCur;

  ddr_trk_ctrl #(.BA_W(BA_W), .BURST_CYC(BURST_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .baQ(baQ), .a10Q(a10Q), .bankOpen(bankOpen), .strb(strb),
    .apBank(apBank), .cmdOut(cmdDec), .powerState(pwrCur),
    .bankErr(bankErr), .ckeErr(ckeErr)
  );

  ddr_trk_dp #(.BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) i_dp (
    .clk(clk), .rstN(rstN), .ba(ba), .addr(addr), .strb(strb), .apBank(apBank),
    .baQ(baQ), .a10Q(a10Q), .bankOpen(bankOpen), .modeBase(modeBase), .modeExt(modeExt)
  );

  assign cmdOut     = cmdDec;
  assign powerState = pwrCur;
endmodule

// File: tb/test_ddr_cmd_tracker.sv
module test_ddr_cmd_tracker;
  logic clk = 1'b0;
  logic rstN, csN, rasN, casN, weN, cke;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  cmdOut;
  logic [1:0]  powerState;
  logic [3:0]  bankOpen;
  logic        bankErr, ckeErr;
  logic [12:0] modeBase, modeExt;
  int nChk = 0, nFail = 0;
  localparam logic [12:0] A10 = 13'h0400;

  always #10 clk = ~clk;

  ddr_cmd_tracker i_ddr_cmd_tracker (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .ba(ba), .addr(addr), .cmdOut(cmdOut), .powerState(powerState),
    .bankOpen(bankOpen), .bankErr(bankErr), .ckeErr(ckeErr),
    .modeBase(modeBase), .modeExt(modeExt)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] code, input logic [1:0] b,
                      input logic [12:0] a, input logic k);
    @(negedge clk);
    {csN, rasN, casN, weN} = code;
    ba = b; addr = a; cke = k;
    @(posedge clk);
    #5;
  endtask

  task automatic nop(input logic k);
    step(4'b1111, 2'd0, 13'd0, k);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; {csN, rasN, casN, weN} = 4'b1111; ba = '0; addr = '0; cke = 1'b1;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
  endtask

  function automatic int expCmd(input logic [3:0] c);
    if (c[3]) return 0;
    case (c[2:0])
      3'b111: return 0; 3'b011: return 1; 3'b101: return 2; 3'b100: return 3;
      3'b010: return 4; 3'b001: return 5; 3'b000: return 7; default: return 8;
    endcase
  endfunction

  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  initial begin
    #(20 * 100000);
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    doReset();
    nop(1);
    check("R1 reset cmdOut", cmdOut, 0);
    check("R8 reset powerState", powerState, 0);
    check("R3 reset bankOpen", bankOpen, 0);
    check("R4 reset bankErr", bankErr, 0);
    check("R7 reset modeBase", modeBase, 0);

    // R1 R2: sweep every chip-select/strobe code across all banks
    for (int i = 0; i < 16; i++)
      for (int b = 0; b < 4; b++) begin
        step(4'(i), 2'(b), 13'd0, 1'b1);
        check($sformatf("R1 decode code %0h bank %0d", i, b), cmdOut, expCmd(4'(i)));
      end

    doReset();
    // R3: open each bank in turn
    for (int b = 0; b < 4; b++) begin
      step(C_ACT, 2'(b), 13'd0, 1'b1);
      nop(1);
      check($sformatf("R3 open bank %0d", b), bankOpen, (2 << b) - 1);
    end
    // R4: ACTIVE to open bank
    step(C_ACT, 2'd0, 13'd0, 1'b1); nop(1);
    check("R4 act-open err", bankErr, 1);
    check("R4 act-open map", bankOpen, 4'hF);
    nop(1);
    check("R4 err one cycle", bankErr, 0);
    // R5
    step(C_PRE, 2'd1, 13'd0, 1'b1); nop(1);
    check("R5 single precharge", bankOpen, 4'b1101);
    step(C_PRE, 2'd3, A10, 1'b1); nop(1);
    check("R5 all precharge", bankOpen, 0);
    // R4: read to closed bank
    step(C_RD, 2'd2, 13'd0, 1'b1); nop(1);
    check("R4 read-closed err", bankErr, 1);
    check("R4 read-closed map", bankOpen, 0);
    // R2: masked ACTIVE
    step(4'b1011, 2'd3, 13'd0, 1'b1);
    check("R2 masked cmdOut", cmdOut, 0);
    nop(1);
    check("R2 masked map", bankOpen, 0);
    // R6: auto-precharge timing
    step(C_ACT, 2'd2, 13'd0, 1'b1); nop(1);
    step(C_RD, 2'd2, A10, 1'b1);
    repeat (4) nop(1);
    check("R6 bank open before burst end", bankOpen, 4'b0100);
    nop(1);
    check("R6 bank closed at burst end", bankOpen, 0);
    step(C_ACT, 2'd3, 13'd0, 1'b1); nop(1);
    step(C_WR, 2'd3, 13'd0, 1'b1);
    repeat (6) nop(1);
    check("R6 no auto-precharge", bankOpen, 4'b1000);
    // R7
    step(C_LMR, 2'd0, 13'h0123, 1'b1); nop(1);
    check("R7 base load", modeBase, 13'h0123);
    step(C_LMR, 2'd1, 13'h0456, 1'b1); nop(1);
    check("R7 ext load", modeExt, 13'h0456);
    step(C_LMR, 2'd2, 13'h1FFF, 1'b1); nop(1);
    check("R7 bank2 base kept", modeBase, 13'h0123);
    check("R7 bank2 ext kept", modeExt, 13'h0456);
    step(C_PRE, 2'd0, A10, 1'b1); nop(1);
    // R8 R10 R11: precharge power-down
    nop(0); nop(0);
    check("R8 precharge power-down", powerState, 1);
    step(C_ACT, 2'd0, 13'd0, 1'b0);
    check("R10 cmd ignored in power-down", cmdOut, 0);
    nop(0);
    check("R10 map held in power-down", bankOpen, 0);
    step(C_ACT, 2'd1, 13'd0, 1'b1);
    check("R11 exit cycle cmd ignored", cmdOut, 0);
    nop(1);
    check("R11 back to active", powerState, 0);
    check("R11 exit cmd had no effect", bankOpen, 0);
    // R8: active power-down
    step(C_ACT, 2'd0, 13'd0, 1'b1); nop(1);
    nop(0); nop(0);
    check("R8 active power-down", powerState, 2);
    nop(1); nop(1);
    check("R11 exit active power-down", powerState, 0);
    // R9: self refresh
    step(C_PRE, 2'd0, A10, 1'b1); nop(1);
    step(C_REF, 2'd0, 13'd0, 1'b0);
    check("R9 self refresh decode", cmdOut, 6);
    nop(0);
    check("R9 self refresh state", powerState, 3);
    nop(1); nop(1);
    check("R11 exit self refresh", powerState, 0);
    step(C_ACT, 2'd1, 13'd0, 1'b1); nop(1);
    step(C_REF, 2'd0, 13'd0, 1'b0);
    check("R9 refresh with open bank decode", cmdOut, 0);
    nop(0);
    check("R9 refresh with open bank state", powerState, 2);
    nop(1); nop(1);
    // R12: CKE drop windows (bank1 open)
    step(C_RD, 2'd1, 13'd0, 1'b1);
    nop(0); nop(0);
    check("R12 drop first burst cycle", ckeErr, 1);
    check("R12 state after drop", powerState, 2);
    nop(1); nop(1);
    check("R12 err one cycle", ckeErr, 0);
    step(C_RD, 2'd1, 13'd0, 1'b1);
    repeat (3) nop(1);
    nop(0); nop(0);
    check("R12 drop last burst cycle", ckeErr, 1);
    nop(1); nop(1);
    step(C_RD, 2'd1, A10, 1'b1);
    repeat (3) nop(1);
    nop(0); nop(0);
    check("R12 drop discards auto-precharge", bankOpen, 4'b0010);
    nop(1); nop(1);
    step(C_RD, 2'd1, 13'd0, 1'b1);
    repeat (4) nop(1);
    nop(0); nop(0);
    check("R12 drop after burst no err", ckeErr, 0);
    check("R12 drop after burst state", powerState, 2);
    nop(1); nop(1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule